// File: doc/BRIEF.md
# Three-wire serial EEPROM slave model

This block is a synthesizable stand-in for a small three-wire serial EEPROM. A host selects it with a chip-select line, clocks instruction bits in on a data-in line with a serial clock, and reads words or status back on a data-out line. A register file takes the place of the nonvolatile cells. It holds 1024 bits, seen either as 64 words of 16 bits or as 128 bytes, as chosen by an organization input. The serial lines are sampled in the system clock domain. A rising serial-clock edge is found by comparing two successive synchronized samples.

Each instruction is a start bit, a two-bit opcode, an address, and for the two writing commands a data word. Every command that changes the array is gated by a write-enable latch. After a change is accepted, a counter stands in for the self-timed programming cycle. The host polls for it by deselecting the block and then selecting it again.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the write-enable latch is clear, data-out is not driven, and a write issued before any enable command leaves the array unchanged and raises no status.
- R2: The data-out enable is low while chip select is low. A read first drives a dummy 0 and then the data word, most significant bit first.
- R3: Opcode 10 reads one word. With org_i high the address is 6 bits and the word is 16 bits.
- R4: With org_i low the address is 7 bits and the data is 8 bits. Byte address 2a is the low byte and 2a+1 the high byte of 16-bit word a.
- R5: Opcode 01 followed by an address and a data word stores that word at that address.
- R6: The extended group uses opcode 00 and is decoded from the top two address bits. Code 11 sets the write-enable latch and code 00 clears it. While the latch is clear, write, erase, erase-all and write-all have no effect.
- R7: Opcode 11 sets the addressed location to all ones.
- R8: Extended code 10 sets every location to all ones. Extended code 01, followed by a data word, writes that word to every location.
- R9: Holding chip select high after a read word continues with the next address, with no further dummy bit. The sequence wraps from the top address to address 0.
- R10: After an accepted modifying command, deselecting and then reselecting drives status on data-out. The status is 0 for PROG_CYCLES clock cycles and 1 after that.
- R11: Instruction bits received while the programming counter runs are ignored.
- R12: Zeros clocked in before the first 1 are ignored. The first 1 is the start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock; data-in is taken on its rising edge |
| di_i | input | 1 | Serial data in |
| org_i | input | 1 | Organization: 1 selects 16-bit words (the idle level), 0 selects bytes |
| do_o | output | 1 | Serial data out or ready status |
| do_oe_o | output | 1 | Output enable for do_o; low means high impedance |

## Verification
A wrong bit count in the command decoder shows up on the first read after the command. Data-out then holds a shifted word, or is missing the dummy 0, within one word time of the last address bit. A write-enable latch that does not hold its state shows up as a word that changes, or fails to change, when the address is next read back. A faulty programming counter shows up when the block is reselected. The status bit then either goes high too early, within about a hundred cycles, or never goes high before the polling limit.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_READ, ST_DONE
  } mw_state_e;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] EX_WDIS  = 2'b00;
  localparam logic [1:0] EX_WRALL = 2'b01;
  localparam logic [1:0] EX_ERALL = 2'b10;
  localparam logic [1:0] EX_WEN   = 2'b11;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] lvl_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= in_i;
      s2_q <= s1_q;
    end
  end

  assign lvl_o = s2_q;
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int PROG_CYCLES = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(PROG_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= CW'(PROG_CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/mw_array.sv
module mw_array #(
  parameter int ADDR_W = 7,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              org_i,
  input  logic              we_i,
  input  logic              all_i,
  input  logic [ADDR_W-1:0] wa_i,
  input  logic [WORD_W-1:0] wd_i,
  input  logic [ADDR_W-1:0] ra_i,
  output logic [WORD_W-1:0] rd_o
);
  localparam int IDX_W  = ADDR_W - 1;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int BYTE_W = WORD_W / 2;

  logic [DEPTH*WORD_W-1:0] flat;
  logic [IDX_W-1:0]        wr_idx, rd_idx;
  logic [WORD_W-1:0]       rd_word;

  assign wr_idx = org_i ? wa_i[IDX_W-1:0] : wa_i[ADDR_W-1:1];
  assign rd_idx = org_i ? ra_i[IDX_W-1:0] : ra_i[ADDR_W-1:1];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk_i) begin
      if (we_i && (all_i || wr_idx == IDX_W'(gi))) begin
        if (all_i && !org_i)      word_q <= {2{wd_i[BYTE_W-1:0]}};
        else if (org_i || all_i)  word_q <= wd_i;
        else if (wa_i[0])         word_q[WORD_W-1:BYTE_W] <= wd_i[BYTE_W-1:0];
        else                      word_q[BYTE_W-1:0]      <= wd_i[BYTE_W-1:0];
      end
    end
    assign flat[gi*WORD_W +: WORD_W] = word_q;
  end

  assign rd_word = flat[rd_idx*WORD_W +: WORD_W];
  assign rd_o = org_i ? rd_word
              : {BYTE_W'(0), ra_i[0] ? rd_word[WORD_W-1:BYTE_W] : rd_word[BYTE_W-1:0]};
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int WORD_W      = 16,
  parameter int PROG_CYCLES = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  input  logic org_i,
  output logic do_o,
  output logic do_oe_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [2:0] lvl;
  logic       cs_q, sk_q, di_q, sk_d_q, sk_rise;

  mw_sync #(.W(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  ({cs_i, sk_i, di_i}),
    .lvl_o (lvl)
  );
  assign {cs_q, sk_q, di_q} = lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sk_d_q <= 1'b0;
    else         sk_d_q <= sk_q;
  end
  assign sk_rise = sk_q & ~sk_d_q;

  mw_state_e         state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n, aw_c, dw_c;
  logic [1:0]        opc_q, opc_n, ext_c;
  logic [ADDR_W-1:0] addr_q, addr_n, addr_in, addr_inc, amask, rd_addr;
  logic [WORD_W-1:0] data_q, data_n, data_in, rd_sh_q, rd_sh_n, rd_data;
  logic              do_q, do_n, wen_q, wen_n, stat_q, stat_n;
  logic              busy, mem_we, mem_all;
  logic [ADDR_W-1:0] mem_wa;
  logic [WORD_W-1:0] mem_wd;

  assign aw_c     = org_i ? CNT_W'(ADDR_W - 1) : CNT_W'(ADDR_W);
  assign dw_c     = org_i ? CNT_W'(WORD_W) : CNT_W'(WORD_W / 2);
  assign amask    = org_i ? {1'b0, {(ADDR_W-1){1'b1}}} : {ADDR_W{1'b1}};
  assign addr_in  = {addr_q[ADDR_W-2:0], di_q} & amask;
  assign addr_inc = (addr_q + ADDR_W'(1)) & amask;
  assign ext_c    = org_i ? addr_in[ADDR_W-2 -: 2] : addr_in[ADDR_W-1 -: 2];
  assign data_in  = {data_q[WORD_W-2:0], di_q};
  assign rd_addr  = (state_q == ST_READ) ? addr_inc : addr_in;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    opc_n   = opc_q;
    addr_n  = addr_q;
    data_n  = data_q;
    rd_sh_n = rd_sh_q;
    do_n    = do_q;
    wen_n   = wen_q;
    stat_n  = stat_q;
    mem_we  = 1'b0;
    mem_all = 1'b0;
    mem_wa  = addr_in;
    mem_wd  = '1;
    if (!cs_q) begin
      state_n = ST_IDLE;
    end else if (sk_rise) begin
      case (state_q)
        ST_IDLE: if (di_q && !busy) begin
          state_n = ST_OPC;
          cnt_n   = '0;
          stat_n  = 1'b0;
        end
        ST_OPC: begin
          opc_n = {opc_q[0], di_q};
          if (cnt_q == CNT_W'(1)) begin
            state_n = ST_ADDR;
            cnt_n   = '0;
            addr_n  = '0;
          end else begin
            cnt_n = cnt_q + CNT_W'(1);
          end
        end
        ST_ADDR: begin
          addr_n = addr_in;
          cnt_n  = cnt_q + CNT_W'(1);
          if (cnt_q == aw_c - CNT_W'(1)) begin
            cnt_n   = '0;
            state_n = ST_DONE;
            case (opc_q)
              OP_READ: begin
                state_n = ST_READ;
                rd_sh_n = rd_data;
                do_n    = 1'b0;   // dummy bit ahead of data
              end
              OP_ERASE: mem_we = wen_q;
              OP_WRITE: begin
                state_n = ST_DATA;
                data_n  = '0;
              end
              default: begin
                case (ext_c)
                  EX_WEN:   wen_n = 1'b1;
                  EX_WDIS:  wen_n = 1'b0;
                  EX_ERALL: begin
                    mem_we  = wen_q;
                    mem_all = 1'b1;
                  end
                  default: begin
                    state_n = ST_DATA;
                    data_n  = '0;
                  end
                endcase
              end
            endcase
          end
        end
        ST_DATA: begin
          data_n = data_in;
          cnt_n  = cnt_q + CNT_W'(1);
          if (cnt_q == dw_c - CNT_W'(1)) begin
            state_n = ST_DONE;
            mem_we  = wen_q;
            mem_all = (opc_q == OP_EXT);
            mem_wa  = addr_q;
            mem_wd  = data_in;
          end
        end
        ST_READ: begin
          do_n = rd_sh_q[dw_c - CNT_W'(1)];
          if (cnt_q == dw_c - CNT_W'(1)) begin
            cnt_n   = '0;
            addr_n  = addr_inc;
            rd_sh_n = rd_data;
          end else begin
            cnt_n   = cnt_q + CNT_W'(1);
            rd_sh_n = {rd_sh_q[WORD_W-2:0], 1'b0};
          end
        end
        default: ;
      endcase
    end
    if (mem_we) stat_n = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      opc_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      rd_sh_q <= '0;
      do_q    <= 1'b0;
      wen_q   <= 1'b0;
      stat_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      opc_q   <= opc_n;
      addr_q  <= addr_n;
      data_q  <= data_n;
      rd_sh_q <= rd_sh_n;
      do_q    <= do_n;
      wen_q   <= wen_n;
      stat_q  <= stat_n;
    end
  end

  mw_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_array (
    .clk_i(clk_i),
    .org_i(org_i),
    .we_i (mem_we),
    .all_i(mem_all),
    .wa_i (mem_wa),
    .wd_i (mem_wd),
    .ra_i (rd_addr),
    .rd_o (rd_data)
  );

  mw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(mem_we),
    .busy_o (busy)
  );

  assign do_o    = (state_q == ST_READ) ? do_q : ~busy;
  assign do_oe_o = cs_q & ((state_q == ST_READ) | ((state_q == ST_IDLE) & stat_q));
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
  import mw_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      cs_q,
  input mw_state_e state_q,
  input logic      mem_we,
  input logic      wen_q,
  input logic      busy,
  input logic      do_oe_o
);
  assert_idle_when_deselected_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_q |=> state_q == ST_IDLE);

  assert_no_drive_when_deselected_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_q |-> !do_oe_o);

  assert_write_needs_enable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> wen_q);

  assert_write_starts_timer_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |=> busy);

  assert_busy_blocks_start_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && state_q == ST_IDLE) |=> state_q == ST_IDLE);
endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs_q   (cs_q),
  .state_q(state_q),
  .mem_we (mem_we),
  .wen_q  (wen_q),
  .busy   (busy),
  .do_oe_o(do_oe_o)
);

// File: tb/sim_mw_eeprom.sv
module sim_mw_eeprom;
  localparam int PROG = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
  logic do_w, do_oe;
  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  mw_eeprom #(.PROG_CYCLES(PROG)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di), .org_i(org),
    .do_o(do_w), .do_oe_o(do_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sk_bit(input logic b);
    di = b; tick(3);
    sk = 1'b1; tick(4);
    sk = 1'b0; tick(3);
  endtask

  task automatic sel();
    cs = 1'b1; tick(4);
  endtask

  task automatic desel();
    cs = 1'b0; di = 1'b0; tick(4);
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [6:0] a);
    sk_bit(1'b1);
    sk_bit(op[1]);
    sk_bit(op[0]);
    for (int i = (org ? 5 : 6); i >= 0; i--) sk_bit(a[i]);
  endtask

  task automatic send_data(input logic [15:0] d);
    for (int i = (org ? 15 : 7); i >= 0; i--) sk_bit(d[i]);
  endtask

  task automatic wait_ready();
    sel();
    for (int i = 0; i < 2000 && do_w !== 1'b1; i++) tick(1);
    desel();
  endtask

  task automatic cmd_write(input logic [6:0] a, input logic [15:0] d);
    sel(); send_hdr(2'b01, a); send_data(d); desel();
  endtask

  task automatic cmd_erase(input logic [6:0] a);
    sel(); send_hdr(2'b11, a); desel();
  endtask

  task automatic cmd_ext(input logic [1:0] ext, input logic [15:0] d);
    sel();
    send_hdr(2'b00, org ? {1'b0, ext, 4'b0} : {ext, 5'b0});
    if (ext == 2'b01) send_data(d);
    desel();
  endtask

  task automatic read_check(input string req, input int lead, input logic [6:0] a, input int n,
                            input logic [15:0] e0, input logic [15:0] e1, input logic [15:0] e2);
    logic [15:0] exp [3];
    logic [15:0] got;
    exp[0] = e0; exp[1] = e1; exp[2] = e2;
    sel();
    for (int i = 0; i < lead; i++) sk_bit(1'b0);
    send_hdr(2'b10, a);
    check({req, " dummy bit"}, {15'b0, do_w}, 16'h0000);
    for (int k = 0; k < n; k++) begin
      got = '0;
      for (int b = 0; b < (org ? 16 : 8); b++) begin
        sk_bit(1'b0);
        got = {got[14:0], do_w};
      end
      check(req, got, exp[k]);
    end
    desel();
  endtask

  task automatic t_reset();
    check("R1 oe after reset", {15'b0, do_oe}, 16'h0);
    sel(); check("R1 oe on select, nothing pending", {15'b0, do_oe}, 16'h0); desel();
    cmd_ext(2'b11, 16'h0);
    cmd_ext(2'b10, 16'h0);
    wait_ready();
    read_check("R8 erase-all addr 0", 0, 7'd0, 1, 16'hFFFF, 0, 0);
    read_check("R8 erase-all addr 63", 0, 7'd63, 1, 16'hFFFF, 0, 0);
    rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(2);
    cmd_write(7'd5, 16'h1234);
    sel(); check("R1 no status after blocked write", {15'b0, do_oe}, 16'h0); desel();
    read_check("R1 write before enable ignored", 0, 7'd5, 1, 16'hFFFF, 0, 0);
  endtask

  task automatic t_write_read();
    cmd_ext(2'b11, 16'h0);
    cmd_write(7'd5, 16'hA5C3); wait_ready();
    read_check("R5 R3 R2 word 5", 0, 7'd5, 1, 16'hA5C3, 0, 0);
    cmd_write(7'd63, 16'h8001); wait_ready();
    read_check("R5 R3 word 63", 0, 7'd63, 1, 16'h8001, 0, 0);
  endtask

  task automatic t_status();
    cmd_write(7'd7, 16'h0F0F);
    sel();
    check("R10 status driven", {15'b0, do_oe}, 16'h1);
    check("R10 status busy", {15'b0, do_w}, 16'h0);
    tick(100);
    check("R10 still busy", {15'b0, do_w}, 16'h0);
    desel();
    tick(PROG);
    sel();
    check("R10 ready", {15'b0, do_w}, 16'h1);
    desel();
    read_check("R10 written word", 0, 7'd7, 1, 16'h0F0F, 0, 0);
  endtask

  task automatic t_busy();
    cmd_write(7'd8, 16'h1111);
    cmd_write(7'd9, 16'h2222);
    wait_ready();
    read_check("R11 command while busy ignored", 0, 7'd9, 1, 16'hFFFF, 0, 0);
    read_check("R11 first command kept", 0, 7'd8, 1, 16'h1111, 0, 0);
  endtask

  task automatic t_protect();
    cmd_ext(2'b00, 16'h0);
    cmd_write(7'd5, 16'h0000);
    cmd_erase(7'd63);
    read_check("R6 write after disable ignored", 0, 7'd5, 1, 16'hA5C3, 0, 0);
    read_check("R6 erase after disable ignored", 0, 7'd63, 1, 16'h8001, 0, 0);
    cmd_ext(2'b11, 16'h0);
    cmd_erase(7'd5); wait_ready();
    read_check("R7 erase sets ones", 0, 7'd5, 1, 16'hFFFF, 0, 0);
  endtask

  task automatic t_byte_mode();
    org = 1'b0; tick(2);
    cmd_write(7'd20, 16'h003C); wait_ready();
    cmd_write(7'd21, 16'h00A7); wait_ready();
    read_check("R4 byte 20", 0, 7'd20, 1, 16'h003C, 0, 0);
    read_check("R4 byte 21", 0, 7'd21, 1, 16'h00A7, 0, 0);
    org = 1'b1; tick(2);
    read_check("R4 word 10 holds both bytes", 0, 7'd10, 1, 16'hA73C, 0, 0);
  endtask

  task automatic t_seq();
    cmd_write(7'd62, 16'h1357); wait_ready();
    cmd_write(7'd0, 16'hBEEF); wait_ready();
    read_check("R9 sequential read with wrap", 0, 7'd62, 3, 16'h1357, 16'h8001, 16'hBEEF);
  endtask

  task automatic t_wral();
    cmd_ext(2'b01, 16'h5AC3); wait_ready();
    read_check("R8 write-all addr 0", 0, 7'd0, 1, 16'h5AC3, 0, 0);
    read_check("R8 write-all addr 40", 0, 7'd40, 1, 16'h5AC3, 0, 0);
    org = 1'b0; tick(2);
    cmd_ext(2'b01, 16'h0066); wait_ready();
    read_check("R8 R4 byte write-all", 0, 7'd77, 1, 16'h0066, 0, 0);
    org = 1'b1; tick(2);
    read_check("R8 R4 byte write-all word view", 0, 7'd33, 1, 16'h6666, 0, 0);
  endtask

  task automatic t_lead_zeros();
    read_check("R12 leading zeros ignored", 3, 7'd40, 1, 16'h6666, 0, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(3);
    t_reset();
    t_write_read();
    t_status();
    t_busy();
    t_protect();
    t_byte_mode();
    t_seq();
    t_wral();
    t_lead_zeros();
    finish_run();
  end
endmodule